// File: doc/BRIEF.md
# Dual-Select Byte-Wide Static Memory Model

This block is a clocked, synthesizable stand-in for a byte-wide asynchronous static memory. The real part has one shared bidirectional data bus. The model splits that bus into an input byte, an output byte and an output-drive flag that stands for the three-state buffer. Two chip selects of opposite polarity gate the part. The model decodes the select, write-enable and output-enable levels into one of four operating modes on every cycle. It reports the decoded mode as a 3-bit code, and it raises a standby flag. A retention flag follows the standby flag once standby has lasted long enough.

A write is framed by the overlap of both selects being active with write enable low. The window opens on whichever of the three events comes last and closes on whichever reverse event comes first. The byte is committed once, when the window closes, using the address and data captured on the last clock edge inside the window. Reads are registered: the bus drives on the edge after read mode is seen. A write-then-read bypass lets the byte just committed appear at once when output enable is held low through the write.

The full part has a 17-bit address. The storage itself is a parameterised window of 2^`DEPTH_AW` words starting at address 0. Setting `DEPTH_AW` to 17 gives the full 128K x 8 array. With a smaller window, addresses above it are unpopulated.

Top module: `dsram_model`

## Requirements
- R1: The array holds 2^DEPTH_AW bytes. A byte written to an address inside the window (address bits at and above DEPTH_AW all zero) reads back unchanged, indexed by address bits [DEPTH_AW-1:0].
- R2: When `sel_n` is 1 or `sel_hi` is 0, `mode` is 3'd0 (standby) and `standby` is 1 at once. On the next edge `dout_oe` is 0, and no write happens whatever `wr_n`, `out_en_n`, `addr` and `din` do.
- R3: When selected with `wr_n`=1 and `out_en_n`=1, `mode` is 3'd1 (output disabled). `dout_oe` is 0 after the next edge and the array is unchanged.
- R4: When selected with `wr_n`=1 and `out_en_n`=0, `mode` is 3'd2 (read). After the next edge `dout_oe` is 1 and `dout` holds the byte at the address sampled on that edge.
- R5: When selected with `wr_n`=0, `mode` is 3'd3 (write) whatever `out_en_n` is, and `dout_oe` is 0 after the next edge.
- R6: The write window is open on a cycle when `sel_n`=0, `sel_hi`=1 and `wr_n`=0. It may open on any of the three and close on any of the three. The byte is committed on the first edge that samples the window closed, using the address and `din` sampled on the last edge with the window open.
- R7: If `sel_n` falls together with or after the fall of `wr_n`, `dout_oe` stays 0 through that write.
- R8: With `out_en_n` held 0 through a write, the edge that ends the window drives `dout_oe`=1 with the byte now stored at the current address, including the byte just written.
- R9: `retain` is 1 only while in standby after at least RET_CYC consecutive edges have sampled standby. It drops in the same cycle that the part is selected.
- R10: A write to an address outside the window is dropped. A read of such an address drives 8'h00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel_n | input | 1 | Chip select, active low |
| sel_hi | input | 1 | Chip select, active high |
| wr_n | input | 1 | Write enable, active low |
| out_en_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Byte address |
| din | input | DATA_W | Data driven onto the bus by the host |
| dout | output | DATA_W | Data the part would drive onto the bus |
| dout_oe | output | 1 | 1 when the part drives the bus, 0 for high-Z |
| mode | output | 3 | Decoded mode: 0 standby, 1 output disabled, 2 read, 3 write |
| standby | output | 1 | Part is deselected |
| retain | output | 1 | Standby has lasted at least RET_CYC edges |

## Verification
The assertions assume that the control levels are clean at each sampling edge. They also assume that any change of select or write enable shows up as a level difference between two successive edges, since a glitch shorter than a clock cannot frame a write here. The bench changes every input only on the falling clock edge and holds it for at least one full cycle. It keeps the address and data steady for the whole of each write window, except where a test moves them on purpose to show that the last in-window sample wins. Reads follow writes only after the closing edge, so each expected byte comes from the bench's own shadow array.

// File: rtl/dsram_pkg.sv
package dsram_pkg;

  typedef enum logic [2:0] {
    M_STBY  = 3'd0,
    M_ODIS  = 3'd1,
    M_READ  = 3'd2,
    M_WRITE = 3'd3
  } mode_e;

  // Both selects active: low one low, high one high.
  function automatic logic is_selected(input logic sel_n, input logic sel_hi);
    return (!sel_n) && sel_hi;
  endfunction

  // Mode priority: deselect wins, then write, then read, else output disabled.
  function automatic mode_e decode_mode(input logic sel_n, input logic sel_hi,
                                        input logic wr_n, input logic out_en_n);
    if (!is_selected(sel_n, sel_hi)) return M_STBY;
    if (!wr_n)                       return M_WRITE;
    if (!out_en_n)                   return M_READ;
    return M_ODIS;
  endfunction

  // Overlap of the three write-framing levels.
  function automatic logic write_open(input logic sel_n, input logic sel_hi,
                                      input logic wr_n);
    return is_selected(sel_n, sel_hi) && !wr_n;
  endfunction

endpackage

// File: rtl/dsram_mode_dec.sv
module dsram_mode_dec
  import dsram_pkg::*;
(
  input  logic  sel_n,
  input  logic  sel_hi,
  input  logic  wr_n,
  input  logic  out_en_n,
  output mode_e mode,
  output logic  in_window,
  output logic  is_stby
);

  assign mode      = decode_mode(sel_n, sel_hi, wr_n, out_en_n);
  assign in_window = write_open(sel_n, sel_hi, wr_n);
  assign is_stby   = !is_selected(sel_n, sel_hi);

endmodule

// File: rtl/dsram_wr_track.sv
module dsram_wr_track #(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_window,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output logic              commit,
  output logic [ADDR_W-1:0] c_addr,
  output logic [DATA_W-1:0] c_data
);

  logic              win_q;
  logic [ADDR_W-1:0] hold_addr;
  logic [DATA_W-1:0] hold_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q     <= 1'b0;
      hold_addr <= '0;
      hold_data <= '0;
    end else begin
      win_q <= in_window;
      if (in_window) begin
        hold_addr <= addr;
        hold_data <= din;
      end
    end
  end

  // Window sampled open last edge, closed now: commit on this edge.
  assign commit = win_q && !in_window;
  assign c_addr = hold_addr;
  assign c_data = hold_data;

  // R6: the hold registers move only while the window is open.
  a_r6_hold_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    !in_window |=> $stable(hold_data) && $stable(hold_addr));

endmodule

// File: rtl/dsram_array.sv
module dsram_array #(
  parameter int DEPTH_AW = 10,
  parameter int DATA_W   = 8
) (
  input  logic                clk,
  input  logic                we,
  input  logic [DEPTH_AW-1:0] waddr,
  input  logic [DATA_W-1:0]   wdata,
  input  logic [DEPTH_AW-1:0] raddr,
  output logic [DATA_W-1:0]   rdata
);

  localparam int DEPTH = 1 << DEPTH_AW;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  // Bypass: a byte committing on this edge is what a read sees.
  assign rdata = (we && (waddr == raddr)) ? wdata : mem[raddr];

endmodule

// File: rtl/dsram_ret_timer.sv
module dsram_ret_timer #(
  parameter int RET_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic is_stby,
  output logic retain
);

  localparam int CW = $clog2(RET_CYC + 1);
  localparam logic [CW-1:0] FULL = CW'(RET_CYC);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt <= '0;
    else if (!is_stby)    cnt <= '0;
    else if (cnt != FULL) cnt <= cnt + 1'b1;
  end

  assign retain = is_stby && (cnt == FULL);

  // R9: retention is only reached after standby was already sampled.
  a_r9_retain_after_stby: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(retain) |-> $past(is_stby));

endmodule

// File: rtl/dsram_model.sv
module dsram_model
  import dsram_pkg::*;
#(
  parameter int ADDR_W   = 17,
  parameter int DATA_W   = 8,
  parameter int DEPTH_AW = 10,
  parameter int RET_CYC  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_n,
  input  logic              sel_hi,
  input  logic              wr_n,
  input  logic              out_en_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic              dout_oe,
  output logic [2:0]        mode,
  output logic              standby,
  output logic              retain
);

  mode_e             dec_mode;
  logic              in_window;
  logic              is_stby;
  logic              commit;
  logic [ADDR_W-1:0] c_addr;
  logic [DATA_W-1:0] c_data;
  logic              c_inrange;
  logic              r_inrange;
  logic              arr_we;
  logic [DATA_W-1:0] arr_rdata;
  logic [DATA_W-1:0] rd_byte;

  dsram_mode_dec u_dec (
    .sel_n    (sel_n),
    .sel_hi   (sel_hi),
    .wr_n     (wr_n),
    .out_en_n (out_en_n),
    .mode     (dec_mode),
    .in_window(in_window),
    .is_stby  (is_stby)
  );

  dsram_wr_track #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_wr (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_window(in_window),
    .addr     (addr),
    .din      (din),
    .commit   (commit),
    .c_addr   (c_addr),
    .c_data   (c_data)
  );

  // Only the low window of the address space is populated.
  assign c_inrange = (c_addr >> DEPTH_AW) == '0;
  assign r_inrange = (addr   >> DEPTH_AW) == '0;
  assign arr_we    = commit && c_inrange;

  dsram_array #(.DEPTH_AW(DEPTH_AW), .DATA_W(DATA_W)) u_arr (
    .clk  (clk),
    .we   (arr_we),
    .waddr(c_addr[DEPTH_AW-1:0]),
    .wdata(c_data),
    .raddr(addr[DEPTH_AW-1:0]),
    .rdata(arr_rdata)
  );

  assign rd_byte = r_inrange ? arr_rdata : '0;

  dsram_ret_timer #(.RET_CYC(RET_CYC)) u_ret (
    .clk    (clk),
    .rst_n  (rst_n),
    .is_stby(is_stby),
    .retain (retain)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout_oe <= 1'b0;
      dout    <= '0;
    end else begin
      dout_oe <= (dec_mode == M_READ);
      dout    <= rd_byte;
    end
  end

  assign mode    = dec_mode;
  assign standby = is_stby;

  // R2: deselected part releases the bus.
  a_r2_stby_hiz: assert property (@(posedge clk) disable iff (!rst_n)
    standby |=> !dout_oe);
  // R3: output-disable mode keeps the bus released.
  a_r3_odis_hiz: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd1) |=> !dout_oe);
  // R4: read mode drives the bus on the next edge.
  a_r4_read_drives: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd2) |=> dout_oe);
  // R5: write mode never drives, whatever output enable does.
  a_r5_write_hiz: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd3) |=> !dout_oe);
  // R6: a commit always follows a cycle decoded as write.
  a_r6_commit_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> ($past(dec_mode) == M_WRITE));
  // R7: select falling onto a low write enable leaves the bus released.
  a_r7_late_select_hiz: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(sel_n) && !wr_n) |=> !dout_oe);

endmodule

// File: tb/dsram_model_tb.sv
module dsram_model_tb;

  localparam int CLK_P    = 10;
  localparam int ADDR_W   = 17;
  localparam int DAW      = 8;
  localparam int DEPTH    = 1 << DAW;
  localparam int RET      = 5;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              sel_n = 1'b1, sel_hi = 1'b0, wr_n = 1'b1, out_en_n = 1'b1;
  logic [ADDR_W-1:0] addr = '0;
  logic [7:0]        din = '0;
  logic [7:0]        dout;
  logic              dout_oe;
  logic [2:0]        mode;
  logic              standby;
  logic              retain;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [7:0] shadow [DEPTH];

  always #(CLK_P/2) clk = ~clk;

  dsram_model #(.ADDR_W(ADDR_W), .DATA_W(8), .DEPTH_AW(DAW), .RET_CYC(RET)) u_dut (
    .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .sel_hi(sel_hi), .wr_n(wr_n),
    .out_en_n(out_en_n), .addr(addr), .din(din), .dout(dout), .dout_oe(dout_oe),
    .mode(mode), .standby(standby), .retain(retain)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic ctl(input logic sn, input logic sh, input logic wn, input logic on);
    sel_n = sn; sel_hi = sh; wr_n = wn; out_en_n = on;
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [2:0] exp_mode(input logic sn, input logic sh,
                                          input logic wn, input logic on);
    if (sn || !sh) return 3'd0;
    if (!wn)       return 3'd3;
    return on ? 3'd1 : 3'd2;
  endfunction

  function automatic logic [7:0] pat(input int a);
    return 8'((a * 37 + 11) ^ (a >> 2));
  endfunction

  // Write pulse on wr_n, then output-disable cycle whose edge commits.
  task automatic wr_byte(input int a, input logic [7:0] d);
    addr = ADDR_W'(a); din = d;
    ctl(1'b0, 1'b1, 1'b0, 1'b1);
    step();
    ctl(1'b0, 1'b1, 1'b1, 1'b1);
    step();
  endtask

  task automatic rd_chk(input string req, input int a, input logic [7:0] expv);
    addr = ADDR_W'(a);
    ctl(1'b0, 1'b1, 1'b1, 1'b0);
    step();
    chk({req, " drive"}, 32'(dout_oe), 32'd1);
    chk({req, " data"}, 32'(dout), 32'(expv));
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    // Reset state
    repeat (3) @(negedge clk);
    chk("R2 reset dout_oe", 32'(dout_oe), 32'd0);
    chk("R9 reset retain", 32'(retain), 32'd0);
    rst_n = 1'b1;
    step();
    chk("R2 reset mode", 32'(mode), 32'd0);
    chk("R2 reset standby", 32'(standby), 32'd1);

    // Mode table sweep: all 16 control combinations (R2 R3 R4 R5)
    addr = ADDR_W'(3); din = 8'h5A;
    for (int i = 0; i < 16; i++) begin
      logic sn, sh, wn, on;
      {sn, sh, wn, on} = 4'(i);
      ctl(sn, sh, wn, on);
      #1;
      chk("R2/R3/R4/R5 mode code", 32'(mode), 32'(exp_mode(sn, sh, wn, on)));
      chk("R2 standby flag", 32'(standby), 32'(sn || !sh));
      step();
      chk("R2/R3/R4/R5 bus drive", 32'(dout_oe), 32'(exp_mode(sn, sh, wn, on) == 3'd2));
    end
    shadow[3] = 8'h5A;

    // Pattern over whole window (R1), then read back
    for (int a = 0; a < DEPTH; a++) begin
      wr_byte(a, pat(a));
      shadow[a] = pat(a);
    end
    for (int a = 0; a < DEPTH; a++) rd_chk("R1 R4 readback", a, shadow[a]);

    // R10: out-of-window write dropped, read returns zero
    wr_byte(DEPTH + 5, 8'hEE);
    rd_chk("R10 out-of-window read", DEPTH + 5, 8'h00);
    rd_chk("R10 alias untouched", 5, shadow[5]);

    // R2: deselected write attempts ignored
    addr = ADDR_W'(7); din = ~shadow[7];
    ctl(1'b0, 1'b0, 1'b0, 1'b1); step(); step();
    ctl(1'b1, 1'b1, 1'b0, 1'b0); step(); step();
    chk("R2 no drive in standby", 32'(dout_oe), 32'd0);
    rd_chk("R2 standby ignores write", 7, shadow[7]);

    // R3: output disable does not write
    addr = ADDR_W'(9); din = ~shadow[9];
    ctl(1'b0, 1'b1, 1'b1, 1'b1); step(); step();
    chk("R3 no drive", 32'(dout_oe), 32'd0);
    rd_chk("R3 no write", 9, shadow[9]);

    // R7: select falls after write enable, output enable low
    addr = ADDR_W'(12); din = 8'hC3;
    ctl(1'b1, 1'b1, 1'b0, 1'b0); step();
    ctl(1'b0, 1'b1, 1'b0, 1'b0); step();
    chk("R7 select after wr_n", 32'(dout_oe), 32'd0);
    // R8: release write enable with output enable low
    ctl(1'b0, 1'b1, 1'b1, 1'b0); step();
    shadow[12] = 8'hC3;
    chk("R8 drive after write", 32'(dout_oe), 32'd1);
    chk("R8 new byte", 32'(dout), 32'hC3);

    // R7: select and write enable fall together
    ctl(1'b1, 1'b1, 1'b1, 1'b0); step();
    addr = ADDR_W'(13); din = 8'h3C;
    ctl(1'b0, 1'b1, 1'b0, 1'b0); step();
    chk("R7 simultaneous fall", 32'(dout_oe), 32'd0);
    ctl(1'b0, 1'b1, 1'b1, 1'b0); step();
    shadow[13] = 8'h3C;
    chk("R8 simultaneous then read", 32'(dout), 32'h3C);

    // R6: window opened by sel_hi rising, last in-window data wins, closed by sel_hi
    addr = ADDR_W'(20); din = 8'h11;
    ctl(1'b0, 1'b0, 1'b0, 1'b1); step();
    ctl(1'b0, 1'b1, 1'b0, 1'b1); step();
    din = 8'h22; step();
    din = 8'h99;
    ctl(1'b0, 1'b0, 1'b0, 1'b1); step();
    shadow[20] = 8'h22;
    rd_chk("R6 sel_hi framed", 20, shadow[20]);

    // R6: window closed by sel_n rising, address moved inside window
    addr = ADDR_W'(21); din = 8'h44;
    ctl(1'b0, 1'b1, 1'b0, 1'b1); step();
    addr = ADDR_W'(22); step();
    addr = ADDR_W'(21); din = 8'h77;
    ctl(1'b1, 1'b1, 1'b0, 1'b1); step();
    shadow[22] = 8'h44;
    rd_chk("R6 last address wins", 22, shadow[22]);
    rd_chk("R6 first address kept", 21, shadow[21]);

    // R9: retention flag
    ctl(1'b1, 1'b0, 1'b1, 1'b1);
    for (int k = 0; k < RET - 1; k++) step();
    chk("R9 before threshold", 32'(retain), 32'd0);
    step();
    chk("R9 at threshold", 32'(retain), 32'd1);
    step();
    chk("R9 held", 32'(retain), 32'd1);
    ctl(1'b0, 1'b1, 1'b1, 1'b1);
    #1;
    chk("R9 drops on select", 32'(retain), 32'd0);
    step();

    done = 1'b1;
    summary();
    $finish;
  end

endmodule